// File: doc/BRIEF.md
# Double-Data-Rate Read Burst Sequencer

This block is the device-side read path of a simplified double-data-rate SDRAM. It accepts decoded commands (no-op, bank activate, read, mode load) together with a 2-bit bank number and an address bus. It tracks which banks hold an open row, and it checks that each read waits the row-to-column delay after its activate. For every legal read it plays out a complete strobe sequence and a data burst taken from a small internal array.

The block runs on a clock at twice the command rate. Each period of this clock is a half-cycle "tick", so a read latency of 2.5 command cycles is an exact count of ticks. Commands are sampled only on even ticks, which are the rising edges of the command clock. Four outputs carry the data and the strobe, each with its own output enable. A pad ring turns these into tristate drivers, and a bench can see every high-impedance interval directly. A read that breaks the rules produces no burst and raises an error flag for one command cycle.

Top module: `ddr_rd_seq`

## Requirements
- R1: While reset is held and on the first tick after it, `dq_oe`, `dqs_oe`, `dq_out`, `dqs_out` and `err` are all 0. The mode defaults to burst length 4, read latency 2 and sequential order.
- R2: `cmd` is decoded as 0 = no-op, 1 = activate, 2 = read, 3 = mode load. It is sampled only on even ticks, which are the first tick after reset and every second tick after that. A command present only on an odd tick has no effect.
- R3: A mode load takes `addr[1:0]` as the burst length code (1 = 2 words, 2 = 4, 3 = 8), `addr[2]` as the order (1 = interleaved) and `addr[3]` as the latency (1 = 2.5 cycles, 0 = 2 cycles). A load with length code 0 is ignored entirely.
- R4: An activate opens the addressed bank and latches `addr[ROW_W-1:0]` as its row. A read is legal only to an open bank, at least TRCD command cycles after that bank's last activate, and only while no burst is in progress. An illegal read starts no burst and drives `err` high for the two ticks that follow it. A legal read leaves `err` low.
- R5: A read sampled on tick T drives its first data word (`dq_oe` high) on tick T+c, where c = 4 for latency 2 and c = 5 for latency 2.5.
- R6: `dqs_oe` rises on tick T+c-2. On ticks T+c-2 and T+c-1, `dqs_out` is 0 and `dq_oe` is 0, which is the one-cycle preamble.
- R7: Burst word k (k = 0..BL-1) is driven on tick T+c+k. `dqs_out` is 1 for even k and 0 for odd k, so the strobe makes one edge per word.
- R8: `dq_oe` is low from tick T+c+BL on. `dq_out` reads 0 whenever `dq_oe` is low.
- R9: On tick T+c+BL, `dqs_oe` is 1 and `dqs_out` is 0, which is the half-cycle postamble. From tick T+c+BL+1 on, `dqs_oe` is 0 and `dqs_out` is 0.
- R10: The array word at bank b, row r and column col is the low DQ_W bits of (A*37 + 11), where A = {b, r, col}. A read uses the bank and column sampled with it and the row latched by that bank's activate.
- R11: In sequential order, word k comes from column (col & ~(BL-1)) | ((col + k) & (BL-1)).
- R12: In interleaved order, word k comes from column col ^ k.
- R13: A read issued while a burst is in progress is rejected as in R4. The running burst continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one period is one half-cycle tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 2 | Decoded command, sampled on even ticks |
| bank | input | 2 | Bank number for activate and read |
| addr | input | ADDR_W | Row (activate), column (read) or mode fields (mode load) |
| dq_out | output | DQ_W | Burst data word |
| dq_oe | output | 1 | Data output enable; low means high impedance |
| dqs_out | output | 1 | Data strobe level |
| dqs_oe | output | 1 | Strobe output enable; low means high impedance |
| err | output | 1 | Rejected-read flag, high for one command cycle |

## Verification
Take a read sampled on tick T. The error flag is due on ticks T+1 and T+2. The strobe enable rises at T+c-2, and word k appears at T+c+k. The data enable drops at T+c+BL and the strobe enable at T+c+BL+1. The bench drives every input at a falling edge and holds each command for an even number of ticks. Its j-th sample after a read therefore falls in the middle of tick T+j. At each sample it compares all five outputs with values computed from j, the latched mode and a bench model of the open rows. It keeps sampling past the release of the strobe, so that a late or missing postamble is caught in the same pass.

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq #(
  parameter int DQ_W   = 8,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 4,
  parameter int TRCD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [1:0]        bank,
  input  logic [ADDR_W-1:0] addr,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              dqs_out,
  output logic              dqs_oe,
  output logic              err
);
  localparam logic [1:0] C_ACT = 2'd1, C_RD = 2'd2, C_MODE = 2'd3;
  localparam int AW    = 2 + ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;
  localparam int TW    = 5;
  localparam int RW    = $clog2(TRCD + 1);

  logic              ph;
  logic [1:0]        bl_code;
  logic              bt_q, clh_q;
  logic [3:0]        open_q;
  logic [ROW_W-1:0]  row_q [4];
  logic [RW-1:0]     rcd_q [4];
  logic [TW-1:0]     t_q;
  logic [1:0]        r_bank, r_bl;
  logic [ROW_W-1:0]  r_row;
  logic [COL_W-1:0]  r_col;
  logic              r_bt, r_clh;
  logic [DQ_W-1:0]   mem [DEPTH];
  logic [DQ_W-1:0]   word_q;
  logic              err_q;

  wire slot   = ~ph;
  wire rd_cmd = slot && (cmd == C_RD);
  wire busy   = (t_q != '0);
  wire rd_ok  = open_q[bank] && (rcd_q[bank] == RW'(TRCD)) && !busy;
  wire rd_go  = rd_cmd && rd_ok;

  logic [TW-1:0]    cl_t, bl_n, t_end, t_nx;
  logic [COL_W-1:0] mask, k_nx, col_nx;

  assign cl_t  = r_clh ? TW'(5) : TW'(4);
  assign bl_n  = TW'(1) << r_bl;
  assign t_end = cl_t + bl_n;
  assign t_nx  = rd_go ? TW'(1) : ((busy && t_q != t_end) ? t_q + TW'(1) : '0);
  assign mask  = (COL_W'(1) << r_bl) - COL_W'(1);
  assign k_nx  = COL_W'(t_nx - cl_t);
  assign col_nx = r_bt ? (r_col ^ (k_nx & mask))
                       : ((r_col & ~mask) | ((r_col + k_nx) & mask));

  wire nx_data = (t_nx >= cl_t) && (t_nx < t_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      bl_code <= 2'd2;
      bt_q    <= 1'b0;
      clh_q   <= 1'b0;
      open_q  <= '0;
      for (int i = 0; i < 4; i++) begin
        row_q[i] <= '0;
        rcd_q[i] <= '0;
      end
      err_q   <= 1'b0;
    end else begin
      ph <= ~ph;
      if (slot) err_q <= rd_cmd && !rd_ok;
      if (slot && cmd == C_MODE && addr[1:0] != 2'd0) begin
        bl_code <= addr[1:0];
        bt_q    <= addr[2];
        clh_q   <= addr[3];
      end
      for (int i = 0; i < 4; i++) begin
        if (slot && cmd == C_ACT && bank == 2'(i)) begin
          open_q[i] <= 1'b1;
          row_q[i]  <= addr[ROW_W-1:0];
          rcd_q[i]  <= '0;
        end else if (ph && rcd_q[i] != RW'(TRCD)) begin
          rcd_q[i] <= rcd_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q    <= '0;
      r_bank <= '0;
      r_row  <= '0;
      r_col  <= '0;
      r_bl   <= 2'd2;
      r_bt   <= 1'b0;
      r_clh  <= 1'b0;
    end else begin
      t_q <= t_nx;
      if (rd_go) begin
        r_bank <= bank;
        r_row  <= row_q[bank];
        r_col  <= addr[COL_W-1:0];
        r_bl   <= bl_code;
        r_bt   <= bt_q;
        r_clh  <= clh_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DQ_W'(i * 37 + 11);
      word_q <= '0;
    end else if (nx_data) begin
      word_q <= mem[{r_bank, r_row, col_nx}];
    end
  end

  assign dqs_oe  = busy && (t_q >= cl_t - TW'(2));
  assign dq_oe   = busy && (t_q >= cl_t) && (t_q < t_end);
  assign dqs_out = dq_oe && !(t_q[0] ^ cl_t[0]);
  assign dq_out  = dq_oe ? word_q : '0;
  assign err     = err_q;

  // R6
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe) |=> (dqs_oe && !dqs_out && !dq_oe));
  // R7
  strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> (dqs_out != $past(dqs_out)));
  // R8
  dq_inside_dqs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe);
  // R9
  postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (dqs_oe && !dqs_out));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |=> !dqs_oe);
  // R4
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(cmd) == C_RD));
endmodule

// File: tb/ddr_rd_seq_tb.sv
module ddr_rd_seq_tb;
  localparam int CLK_P = 10;
  localparam int DQ_W = 8, ROW_W = 2, COL_W = 4, ADDR_W = 4, TRCD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd = 2'd0, bank = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DQ_W-1:0] dq_out;
  logic dq_oe, dqs_out, dqs_oe, err;

  int n_run = 0, n_fail = 0, cyc_now = 0;
  int m_bl = 4, m_c = 4, m_bt = 0;
  int b_open [4], b_row [4], b_tact [4];

  always #(CLK_P/2) clk = ~clk;

  ddr_rd_seq #(.DQ_W(DQ_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .TRCD(TRCD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr(addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dqs_out(dqs_out), .dqs_oe(dqs_oe), .err(err));

  function automatic int exp_word(int b, int r, int col);
    int a = (b << (ROW_W + COL_W)) | (r << COL_W) | col;
    return (a * 37 + 11) % (1 << DQ_W);
  endfunction

  function automatic int exp_col(int col, int k, int bl, int bt);
    if (bt != 0) return col ^ k;
    return (col & ~(bl - 1)) | ((col + k) & (bl - 1));
  endfunction

  task automatic ck(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int c, int b, int a);
    cmd = 2'(c); bank = 2'(b); addr = ADDR_W'(a);
    @(negedge clk); @(negedge clk);
    cmd = 2'd0;
    cyc_now++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); @(negedge clk);
      cyc_now++;
    end
  endtask

  task automatic set_mode(int code, int bt, int clh);
    send(3, 0, (clh << 3) | (bt << 2) | code);
    if (code != 0) begin
      m_bl = 1 << code; m_bt = bt; m_c = clh ? 5 : 4;
    end
  endtask

  task automatic activate(int b, int r);
    b_open[b] = 1; b_row[b] = r; b_tact[b] = cyc_now;
    send(1, b, r);
  endtask

  // poke: drive a second read on tick T+2 while the burst runs
  task automatic do_read(int b, int col, bit poke);
    bit legal = (b_open[b] != 0) && (cyc_now - b_tact[b] >= TRCD);
    int c = m_c, bl = m_bl, bt = m_bt, r = b_row[b];
    int len = ((c + bl + 2) + 1) & ~1;
    cmd = 2'd2; bank = 2'(b); addr = ADDR_W'(col);
    for (int j = 1; j <= len; j++) begin
      bit e_dqs_oe, e_dq_oe, e_dqs;
      int e_dq;
      @(negedge clk);
      if (j == 2) begin
        if (poke && legal) begin cmd = 2'd2; addr = ADDR_W'(col ^ 1); end
        else cmd = 2'd0;
      end
      if (j == 4) cmd = 2'd0;
      e_dqs_oe = legal && j >= c - 2 && j <= c + bl;
      e_dq_oe  = legal && j >= c && j < c + bl;
      e_dqs    = e_dq_oe && ((j - c) % 2 == 0);
      e_dq     = e_dq_oe ? exp_word(b, r, exp_col(col, j - c, bl, bt)) : 0;
      if (j <= 2) ck(legal ? "R4 err low on legal read" : "R4 err on illegal read", int'(err), legal ? 0 : 1);
      if (poke && legal && (j == 3 || j == 4)) ck("R13 busy read flagged", int'(err), 1);
      if (j < c) begin
        ck("R6 preamble dqs_oe", int'(dqs_oe), int'(e_dqs_oe));
        ck("R6 preamble dqs low", int'(dqs_out), 0);
        ck("R6 preamble dq_oe", int'(dq_oe), 0);
      end else if (j < c + bl) begin
        ck(j == c ? "R5 first word dq_oe" : "R7 burst dq_oe", int'(dq_oe), int'(e_dq_oe));
        ck("R7 strobe level", int'(dqs_out), int'(e_dqs));
        ck("R7 strobe enable", int'(dqs_oe), int'(e_dqs_oe));
        ck(bt ? "R12 R10 interleaved word" : "R11 R10 sequential word", int'(dq_out), e_dq);
      end else if (j == c + bl) begin
        ck("R8 dq released", int'(dq_oe), 0);
        ck("R8 dq zero", int'(dq_out), 0);
        ck("R9 postamble enable", int'(dqs_oe), int'(e_dqs_oe));
        ck("R9 postamble low", int'(dqs_out), 0);
      end else begin
        ck("R9 strobe released", int'(dqs_oe), 0);
        ck("R9 strobe zero", int'(dqs_out), 0);
        ck("R8 dq stays released", int'(dq_oe), 0);
      end
    end
    cmd = 2'd0;
    cyc_now += len / 2;
  endtask

  task automatic odd_tick_read(int b, int col);
    @(negedge clk);
    cmd = 2'd2; bank = 2'(b); addr = ADDR_W'(col);
    @(negedge clk);
    cmd = 2'd0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      ck("R2 odd-tick read ignored dqs_oe", int'(dqs_oe), 0);
      ck("R2 odd-tick read no err", int'(err), 0);
    end
    cyc_now += 7;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    for (int i = 0; i < 4; i++) begin b_open[i] = 0; b_row[i] = 0; b_tact[i] = 0; end
    repeat (3) @(negedge clk);
    ck("R1 reset dq_oe", int'(dq_oe), 0);
    ck("R1 reset dqs_oe", int'(dqs_oe), 0);
    ck("R1 reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    ck("R1 after reset dq_out", int'(dq_out), 0);
    ck("R1 after reset dqs_out", int'(dqs_out), 0);

    // R4 read to a closed bank
    do_read(1, 2, 1'b0);
    // R4 too early, then legal with default mode (R1 defaults)
    activate(2, 3);
    idle(0);
    do_read(2, 5, 1'b0);
    b_tact[2] = cyc_now;
    activate(0, 1);
    idle(2);
    do_read(0, 5, 1'b0);
    // R2
    odd_tick_read(0, 6);
    // R3 R12 burst 8, interleaved, latency 2.5
    set_mode(3, 1, 1);
    do_read(0, 3, 1'b0);
    // R3 ignored load keeps the previous mode
    set_mode(0, 0, 0);
    do_read(2, 12, 1'b0);
    // R11 burst 2 sequential wrap
    set_mode(1, 0, 0);
    do_read(2, 7, 1'b0);
    // R13
    set_mode(2, 0, 1);
    do_read(0, 14, 1'b1);

    for (int it = 0; it < 60; it++) begin
      int b = $urandom % 4;
      case ($urandom % 4)
        0: set_mode($urandom % 4, $urandom % 2, $urandom % 2);
        1: activate(b, $urandom % 4);
        2: idle($urandom % 3);
        default: do_read(b, $urandom % 16, ($urandom % 4) == 0);
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule